// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a queue of software-written command words and a bit-level I2C engine. Each 10-bit word carries a byte together with two framing flags. The sequencer takes words from a 16-entry transmit queue and turns each one into engine operations: a START or repeated START, an address byte, a data byte, a counted burst of reads, and a STOP. Bytes read from the target are written into a 16-entry receive queue, which the host drains one byte at a time. The SCL/SDA timing and the register decoding sit outside the block.

The engine is driven through a request/done handshake. The sequencer holds a request with a command code until the engine returns a one-cycle done. With the done, the engine also returns the acknowledge bit sampled from the target, an arbitration-lost flag and a read byte. If the target rejects a byte, the sequencer closes the transfer with STOP and reports a transmit error. If arbitration is lost, it drops the bus without STOP. In both cases it discards the words still queued.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A transmit word holds its byte in bits 7:0, a start flag in bit 8 and a stop flag in bit 9. A start-flagged word produces a START command and then a WRITE_BYTE of its byte. That byte is the address: the target address shifted left by one, with bit 0 set to 1 for read and 0 for write.
- R2: A start-flagged word that also has the stop flag set and a write address (bit 0 = 0) produces START, WRITE_BYTE(address) and then STOP.
- R3: After a start word with a read address (bit 0 = 1), the next word is taken as a count N from its bits 7:0. The sequencer issues N READ_BYTE commands. The no-acknowledge flag is 0 on each of them except the last, where it is 1. STOP follows. The read bytes enter the receive queue in order. N = 0 gives STOP straight after the address.
- R4: A start-flagged word that arrives while the bus is held, with no STOP issued yet, produces a new START (a repeated start) with no STOP before it.
- R5: A word without the start flag that arrives while the bus is held produces WRITE_BYTE of its byte. If its stop flag is set, STOP follows. If not, the bus stays held.
- R6: If the target does not acknowledge an address byte or a write byte, the sequencer empties the transmit queue and pulses tx_err_o for exactly one cycle, then issues STOP.
- R7: On arbitration lost, the sequencer issues no STOP. It empties the transmit queue, pulses arb_lost_o for one cycle, drops bus_busy_o and returns to idle.
- R8: While the receive queue is full, no READ_BYTE request is made. Reading resumes once the host pops a byte.
- R9: Each queue holds 16 entries and reports full and empty. A push into the full transmit queue is ignored.
- R10: bus_busy_o rises when a START completes without arbitration loss. It falls when a STOP completes or arbitration is lost.
- R11: The request is held with a stable command, byte and no-acknowledge flag until done. Command codes are START = 0, WRITE_BYTE = 1, READ_BYTE = 2 and STOP = 3.
- R12: A word without the start flag that arrives while the bus is not held is discarded and produces no command.
- R13: After reset, both queues are empty, bus_busy_o is 0 and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Push a command word |
| tx_word_i | input | 10 | Command word: stop flag, start flag, byte |
| tx_full_o | output | 1 | Transmit queue full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_rd_i | input | 1 | Pop a received byte |
| rx_data_o | output | 8 | Oldest received byte |
| rx_full_o | output | 1 | Receive queue full |
| rx_empty_o | output | 1 | Receive queue empty |
| bus_busy_o | output | 1 | Bus held by this master |
| eng_req_o | output | 1 | Engine request |
| eng_cmd_o | output | 2 | Engine command code |
| eng_wdata_o | output | 8 | Byte to write |
| eng_nack_o | output | 1 | Send no-acknowledge on this read |
| eng_done_i | input | 1 | Engine finished the command |
| eng_ack_i | input | 1 | Target acknowledged the byte |
| eng_arb_lost_i | input | 1 | Arbitration lost during the command |
| eng_rdata_i | input | 8 | Byte read by the engine |
| tx_err_o | output | 1 | Pulse: byte not acknowledged |
| arb_lost_o | output | 1 | Pulse: arbitration lost |

## Verification
Most wrong internal states show at the engine port within one command. A lost bus-held flag appears as a missing repeated START or a dropped data word. A bad read count shows as the no-acknowledge flag on the wrong READ_BYTE, or as a missing or extra read before STOP. A queue pointer fault shows as a wrong byte or flag value at the next push or pop. A flush that is skipped after a rejected byte or a lost arbitration shows as stray commands a few cycles later.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned WORD_W    = DATA_W + 2;
  localparam int unsigned BIT_START = DATA_W;
  localparam int unsigned BIT_STOP  = DATA_W + 1;
  localparam int unsigned Q_DEPTH   = 16;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_STOP  = 2'd3
  } eng_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_ADDR, ST_CNT, ST_READ, ST_WRITE, ST_STOP
  } seq_state_e;
endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW:0]      wptr_q, rptr_q, used;
  logic             push_ok, pop_ok;

  assign used    = wptr_q - rptr_q;
  assign full_o  = (used == (AW+1)'(DEPTH));
  assign empty_o = (used == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q[AW-1:0]] <= wdata_i;
  end
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW+1:0] tx_word_i,
  input  logic          tx_empty_i,
  output logic          tx_pop_o,
  output logic          tx_flush_o,
  input  logic          rx_full_i,
  output logic          rx_push_o,
  output logic          eng_req_o,
  output logic [1:0]    eng_cmd_o,
  output logic [DW-1:0] eng_wdata_o,
  output logic          eng_nack_o,
  input  logic          eng_done_i,
  input  logic          eng_ack_i,
  input  logic          eng_arb_lost_i,
  output logic          bus_busy_o,
  output logic          tx_err_o,
  output logic          arb_lost_o
);
  seq_state_e    state_q, state_d;
  logic [DW-1:0] byte_q, byte_d, cnt_q, cnt_d;
  logic          stop_q, stop_d, owned_q, owned_d;
  logic          err_q, err_d, arb_q, arb_d;
  logic          w_start, w_stop;
  logic [DW-1:0] w_byte;

  assign w_byte  = tx_word_i[DW-1:0];
  assign w_start = tx_word_i[DW];
  assign w_stop  = tx_word_i[DW+1];

  always_comb begin
    state_d    = state_q;
    byte_d     = byte_q;
    stop_d     = stop_q;
    cnt_d      = cnt_q;
    owned_d    = owned_q;
    err_d      = 1'b0;
    arb_d      = 1'b0;
    tx_pop_o   = 1'b0;
    tx_flush_o = 1'b0;
    rx_push_o  = 1'b0;
    eng_req_o  = 1'b0;
    eng_cmd_o  = CMD_START;
    eng_nack_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (!tx_empty_i) begin
        tx_pop_o = 1'b1;
        byte_d   = w_byte;
        stop_d   = w_stop;
        if (w_start)      state_d = ST_START;
        else if (owned_q) state_d = ST_WRITE;
      end
      ST_START: begin
        eng_req_o = 1'b1;
        eng_cmd_o = CMD_START;
        if (eng_done_i && !eng_arb_lost_i) begin
          owned_d = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR, ST_WRITE: begin
        eng_req_o = 1'b1;
        eng_cmd_o = CMD_WRITE;
        if (eng_done_i && !eng_arb_lost_i) begin
          if (!eng_ack_i) begin
            tx_flush_o = 1'b1;
            err_d      = 1'b1;
            state_d    = ST_STOP;
          end else if (state_q == ST_ADDR && byte_q[0]) state_d = ST_CNT;
          else if (stop_q)  state_d = ST_STOP;
          else              state_d = ST_IDLE;
        end
      end
      ST_CNT: if (!tx_empty_i) begin
        tx_pop_o = 1'b1;
        cnt_d    = w_byte;
        state_d  = (w_byte == '0) ? ST_STOP : ST_READ;
      end
      ST_READ: begin
        eng_req_o  = !rx_full_i;
        eng_cmd_o  = CMD_READ;
        eng_nack_o = (cnt_q == DW'(1));
        if (eng_done_i && !eng_arb_lost_i) begin
          rx_push_o = 1'b1;
          cnt_d     = cnt_q - 1'b1;
          if (cnt_q == DW'(1)) state_d = ST_STOP;
        end
      end
      ST_STOP: begin
        eng_req_o = 1'b1;
        eng_cmd_o = CMD_STOP;
        if (eng_done_i && !eng_arb_lost_i) begin
          owned_d = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    // arbitration loss abandons any command in flight
    if (state_q != ST_IDLE && state_q != ST_CNT && eng_done_i && eng_arb_lost_i) begin
      tx_flush_o = 1'b1;
      rx_push_o  = 1'b0;
      arb_d      = 1'b1;
      err_d      = 1'b0;
      owned_d    = 1'b0;
      state_d    = ST_IDLE;
    end
  end

  assign eng_wdata_o = byte_q;
  assign bus_busy_o  = owned_q;
  assign tx_err_o    = err_q;
  assign arb_lost_o  = arb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      byte_q  <= '0;
      stop_q  <= 1'b0;
      cnt_q   <= '0;
      owned_q <= 1'b0;
      err_q   <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      stop_q  <= stop_d;
      cnt_q   <= cnt_d;
      owned_q <= owned_d;
      err_q   <= err_d;
      arb_q   <= arb_d;
    end
  end
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned DEPTH = Q_DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_wr_i,
  input  logic [DW+1:0] tx_word_i,
  output logic          tx_full_o,
  output logic          tx_empty_o,
  input  logic          rx_rd_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_full_o,
  output logic          rx_empty_o,
  output logic          bus_busy_o,
  output logic          eng_req_o,
  output logic [1:0]    eng_cmd_o,
  output logic [DW-1:0] eng_wdata_o,
  output logic          eng_nack_o,
  input  logic          eng_done_i,
  input  logic          eng_ack_i,
  input  logic          eng_arb_lost_i,
  input  logic [DW-1:0] eng_rdata_i,
  output logic          tx_err_o,
  output logic          arb_lost_o
);
  localparam int unsigned WW = DW + 2;

  logic [WW-1:0] tx_head;
  logic          tx_pop, tx_flush, rx_push;

  i2c_seq_fifo #(.WIDTH(WW), .DEPTH(DEPTH)) u_tx_q (
    .clk_i, .rst_ni,
    .push_i(tx_wr_i), .wdata_i(tx_word_i), .pop_i(tx_pop), .flush_i(tx_flush),
    .rdata_o(tx_head), .full_o(tx_full_o), .empty_o(tx_empty_o)
  );

  i2c_seq_fifo #(.WIDTH(DW), .DEPTH(DEPTH)) u_rx_q (
    .clk_i, .rst_ni,
    .push_i(rx_push), .wdata_i(eng_rdata_i), .pop_i(rx_rd_i), .flush_i(1'b0),
    .rdata_o(rx_data_o), .full_o(rx_full_o), .empty_o(rx_empty_o)
  );

  i2c_seq_fsm #(.DW(DW)) u_fsm (
    .clk_i, .rst_ni,
    .tx_word_i(tx_head), .tx_empty_i(tx_empty_o), .tx_pop_o(tx_pop), .tx_flush_o(tx_flush),
    .rx_full_i(rx_full_o), .rx_push_o(rx_push),
    .eng_req_o, .eng_cmd_o, .eng_wdata_o, .eng_nack_o,
    .eng_done_i, .eng_ack_i, .eng_arb_lost_i,
    .bus_busy_o, .tx_err_o, .arb_lost_o
  );
endmodule

// File: rtl/i2c_cmd_seq_chk.sv
module i2c_cmd_seq_chk
  import i2c_seq_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_full_o,
  input logic          tx_empty_o,
  input logic          rx_full_o,
  input logic          bus_busy_o,
  input logic          eng_req_o,
  input logic [1:0]    eng_cmd_o,
  input logic [DW-1:0] eng_wdata_o,
  input logic          eng_nack_o,
  input logic          eng_done_i,
  input logic          tx_err_o,
  input logic          arb_lost_o
);
  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_done_i |=> eng_req_o && $stable(eng_cmd_o) &&
      $stable(eng_wdata_o) && $stable(eng_nack_o));

  assert_no_read_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && eng_cmd_o == CMD_READ |-> !rx_full_o);

  assert_err_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |-> tx_empty_o && eng_req_o && eng_cmd_o == CMD_STOP);

  assert_err_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_o |=> !tx_err_o);

  assert_arb_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> !bus_busy_o && tx_empty_o);

  assert_busy_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_busy_o) |-> $past(eng_done_i) && $past(eng_cmd_o) == CMD_START);

  assert_busy_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_busy_o) |-> $past(eng_done_i) && $past(eng_req_o));

  assert_stop_owned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && eng_cmd_o == CMD_STOP |-> bus_busy_o);

  assert_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_o && tx_empty_o));
endmodule

bind i2c_cmd_seq i2c_cmd_seq_chk #(.DW(DW)) chk_i (.*);

// File: tb/i2c_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_seq_tb_top;
  localparam int LAT = 2;
  typedef struct packed { logic [1:0] c; logic [7:0] d; logic n; } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tx_wr_i = 1'b0, rx_rd_i = 1'b0;
  logic [9:0] tx_word_i = '0;
  logic tx_full_o, tx_empty_o, rx_full_o, rx_empty_o, bus_busy_o;
  logic [7:0] rx_data_o, eng_wdata_o;
  logic eng_req_o, eng_nack_o, tx_err_o, arb_lost_o;
  logic [1:0] eng_cmd_o;
  logic eng_done_i = 1'b0, eng_ack_i = 1'b0, eng_arb_lost_i = 1'b0;
  logic [7:0] eng_rdata_i = '0;

  int tests = 0, fails = 0;
  int cmd_seen = 0, reads_seen = 0, nack_at = -1, arb_at = -1;
  int err_cnt = 0, arbp_cnt = 0;
  bit stall = 0;
  logic [7:0] rd_ctr = 8'h30;
  exp_t exp_q[$];
  logic [7:0] rx_exp[$];

  always #2.5 clk = ~clk;

  i2c_cmd_seq dut_i (
    .clk_i(clk), .rst_ni, .tx_wr_i, .tx_word_i, .tx_full_o, .tx_empty_o,
    .rx_rd_i, .rx_data_o, .rx_full_o, .rx_empty_o, .bus_busy_o,
    .eng_req_o, .eng_cmd_o, .eng_wdata_o, .eng_nack_o,
    .eng_done_i, .eng_ack_i, .eng_arb_lost_i, .eng_rdata_i,
    .tx_err_o, .arb_lost_o
  );

  task automatic chk(string r, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", r, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic expect_cmd(logic [1:0] c, logic [7:0] d, logic n);
    exp_q.push_back('{c: c, d: d, n: n});
  endtask

  task automatic push(logic [9:0] w);
    @(negedge clk); tx_wr_i = 1'b1; tx_word_i = w;
    @(negedge clk); tx_wr_i = 1'b0;
  endtask

  task automatic pop_rx(string r);
    @(negedge clk);
    chk(r, "rx not empty", int'(rx_empty_o), 0);
    if (rx_exp.size() != 0) chk(r, "rx byte", int'(rx_data_o), int'(rx_exp.pop_front()));
    rx_rd_i = 1'b1;
    @(negedge clk); rx_rd_i = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (exp_q.size() != 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (12) @(negedge clk);
  endtask

  // engine model and command scoreboard
  initial forever begin
    @(negedge clk);
    if (eng_req_o && rst_ni) begin
      logic [1:0] c; logic [7:0] d; logic n; exp_t e;
      while (stall) @(negedge clk);
      c = eng_cmd_o; d = eng_wdata_o; n = eng_nack_o;
      if (exp_q.size() == 0) chk("R11", "unexpected command", int'(c), 4);
      else begin
        e = exp_q.pop_front();
        chk("R11", "command code", int'(c), int'(e.c));
        if (e.c == 2'd1) chk("R1", "write byte", int'(d), int'(e.d));
        if (e.c == 2'd2) chk("R3", "nack flag", int'(n), int'(e.n));
      end
      repeat (LAT) @(negedge clk);
      chk("R11", "cmd held until done", int'({eng_req_o, eng_cmd_o}), int'({1'b1, c}));
      eng_done_i = 1'b1;
      eng_ack_i = (cmd_seen != nack_at);
      eng_arb_lost_i = (cmd_seen == arb_at);
      eng_rdata_i = rd_ctr;
      if (c == 2'd2) begin rd_ctr++; reads_seen++; end
      cmd_seen++;
      @(negedge clk);
      eng_done_i = 1'b0; eng_arb_lost_i = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (tx_err_o) err_cnt++;
    if (arb_lost_o) arbp_cnt++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int base, e0, a0;
    repeat (4) @(negedge clk);
    // R13 reset state
    chk("R13", "tx empty", int'(tx_empty_o), 1);
    chk("R13", "rx empty", int'(rx_empty_o), 1);
    chk("R13", "busy", int'(bus_busy_o), 0);
    chk("R13", "req", int'(eng_req_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R2 start+stop with write address 0x50
    expect_cmd(2'd0, 0, 0); expect_cmd(2'd1, 8'hA0, 0); expect_cmd(2'd3, 0, 0);
    push({2'b11, 8'hA0});
    wait_idle();
    chk("R2", "queue drained", exp_q.size(), 0);
    chk("R2", "busy after stop", int'(bus_busy_o), 0);

    // R1 R5 write address 0x42, two data bytes, bus kept
    expect_cmd(2'd0, 0, 0); expect_cmd(2'd1, 8'h84, 0);
    expect_cmd(2'd1, 8'h11, 0); expect_cmd(2'd1, 8'h22, 0);
    push({2'b01, 8'h84}); push({2'b00, 8'h11}); push({2'b00, 8'h22});
    wait_idle();
    chk("R5", "writes done", exp_q.size(), 0);
    chk("R10", "busy held", int'(bus_busy_o), 1);

    // R4 repeated start into a 3-byte read, R3
    base = int'(rd_ctr);
    expect_cmd(2'd0, 0, 0); expect_cmd(2'd1, 8'h85, 0);
    expect_cmd(2'd2, 0, 0); expect_cmd(2'd2, 0, 0); expect_cmd(2'd2, 0, 1);
    expect_cmd(2'd3, 0, 0);
    for (int i = 0; i < 3; i++) rx_exp.push_back(8'(base + i));
    push({2'b01, 8'h85}); push({2'b10, 8'd3});
    wait_idle();
    chk("R4", "repeated start sequence", exp_q.size(), 0);
    chk("R10", "busy after read stop", int'(bus_busy_o), 0);
    for (int i = 0; i < 3; i++) pop_rx("R3");
    chk("R3", "rx drained", int'(rx_empty_o), 1);

    // R3 zero count
    expect_cmd(2'd0, 0, 0); expect_cmd(2'd1, 8'h85, 0); expect_cmd(2'd3, 0, 0);
    push({2'b01, 8'h85}); push({2'b10, 8'd0});
    wait_idle();
    chk("R3", "zero count", exp_q.size(), 0);
    chk("R3", "no rx on zero count", int'(rx_empty_o), 1);

    // R12 data word without bus
    base = cmd_seen;
    push({2'b10, 8'h33});
    repeat (20) @(negedge clk);
    chk("R12", "no command", cmd_seen, base);
    chk("R12", "word consumed", int'(tx_empty_o), 1);

    // R6 address not acknowledged
    e0 = err_cnt; nack_at = cmd_seen + 1;
    expect_cmd(2'd0, 0, 0); expect_cmd(2'd1, 8'h90, 0); expect_cmd(2'd3, 0, 0);
    push({2'b01, 8'h90}); push({2'b00, 8'h44}); push({2'b10, 8'h55});
    wait_idle();
    nack_at = -1;
    chk("R6", "stop after nack", exp_q.size(), 0);
    chk("R6", "err pulses", err_cnt - e0, 1);
    chk("R6", "tx flushed", int'(tx_empty_o), 1);
    chk("R6", "bus freed", int'(bus_busy_o), 0);

    // R6 data byte not acknowledged
    e0 = err_cnt; nack_at = cmd_seen + 2;
    expect_cmd(2'd0, 0, 0); expect_cmd(2'd1, 8'h90, 0);
    expect_cmd(2'd1, 8'h66, 0); expect_cmd(2'd3, 0, 0);
    push({2'b01, 8'h90}); push({2'b00, 8'h66}); push({2'b10, 8'h77});
    wait_idle();
    nack_at = -1;
    chk("R6", "data nack sequence", exp_q.size(), 0);
    chk("R6", "data err pulses", err_cnt - e0, 1);

    // R7 arbitration lost on write byte, no stop
    a0 = arbp_cnt; arb_at = cmd_seen + 1;
    expect_cmd(2'd0, 0, 0); expect_cmd(2'd1, 8'h90, 0);
    push({2'b01, 8'h90}); push({2'b00, 8'h12}); push({2'b10, 8'h34});
    wait_idle();
    arb_at = -1;
    chk("R7", "no stop after arb loss", exp_q.size(), 0);
    chk("R7", "arb pulses", arbp_cnt - a0, 1);
    chk("R7", "busy dropped", int'(bus_busy_o), 0);
    chk("R7", "tx flushed", int'(tx_empty_o), 1);

    // R8 R9 read 18 bytes into a 16-entry rx queue
    base = int'(rd_ctr); a0 = reads_seen;
    expect_cmd(2'd0, 0, 0); expect_cmd(2'd1, 8'hA1, 0);
    for (int i = 0; i < 18; i++) expect_cmd(2'd2, 0, i == 17);
    expect_cmd(2'd3, 0, 0);
    for (int i = 0; i < 18; i++) rx_exp.push_back(8'(base + i));
    push({2'b01, 8'hA1}); push({2'b10, 8'd18});
    repeat (300) @(negedge clk);
    chk("R8", "reads stall at full", reads_seen - a0, 16);
    chk("R9", "rx full", int'(rx_full_o), 1);
    chk("R8", "bus held while stalled", int'(bus_busy_o), 1);
    for (int i = 0; i < 16; i++) pop_rx("R8");
    wait_idle();
    chk("R8", "reads resumed", reads_seen - a0, 18);
    pop_rx("R3"); pop_rx("R3");
    chk("R9", "rx empty", int'(rx_empty_o), 1);

    // R9 tx queue full, extra push ignored
    stall = 1;
    expect_cmd(2'd0, 0, 0); expect_cmd(2'd1, 8'h90, 0);
    for (int i = 0; i < 16; i++) expect_cmd(2'd1, 8'(8'hC0 + i), 0);
    expect_cmd(2'd3, 0, 0);
    push({2'b01, 8'h90});
    repeat (3) @(negedge clk);
    for (int i = 0; i < 16; i++) push({(i == 15) ? 2'b10 : 2'b00, 8'(8'hC0 + i)});
    chk("R9", "tx full", int'(tx_full_o), 1);
    chk("R9", "tx not empty", int'(tx_empty_o), 0);
    push({2'b01, 8'hA4});
    chk("R9", "still full", int'(tx_full_o), 1);
    stall = 0;
    wait_idle();
    repeat (30) @(negedge clk);
    chk("R9", "all 16 words sent", exp_q.size(), 0);
    chk("R9", "tx drained", int'(tx_empty_o), 1);
    chk("R5", "bus released by stop flag", int'(bus_busy_o), 0);

    summary();
  end
endmodule